// File: doc/BRIEF.md
# Serial-Link Interrupt Pending Aggregator

This block collects every interrupt source of a serial inter-chip link port into a single pending register and drives one level interrupt towards the host CPU. It has three kinds of source. Status words come from received interrupt packets. Error pulses report a corrupted inbound packet (local error) or a transmit error flagged by the far end (remote error). A link-up indication also counts as a source, because the first time the link comes up it raises a spurious remote-error flag.

Software reaches four registers through a simple zero-wait-state bus: control, status, interrupt pointer and pending. Each received status word is handled as a write to whichever local register the pointer names. Remote delivery is allowed only while the control register's local-delivery bit is set. With the pointer at the pending register's offset, remote words OR into the pending bits. When error posting is enabled, each error event also sets the one pending bit picked by the control register's vector field. Software acknowledges pending bits and error flags by writing ones.

Register map: control at 00h, status at 04h, pointer at 08h, pending at 14h. Control layout: bit 0 is local delivery enable, bit 1 is error posting enable, bits 12:8 are the vector. Status layout: bit 0 is link, bit 1 is local error, bit 2 is remote error.

Top module: `lnk_irq_aggr`

## Requirements
- R1: With local delivery on and the pointer at 14h, a remote word ORs into the pending register at the next clock edge. Bits already pending are kept.
- R2: With local delivery off (control bit 0 = 0), a remote word changes no register.
- R3: A remote word goes to the register whose offset exactly equals the pointer. At 00h it overwrites control. At 08h it overwrites the pointer. At 04h it acts as a write-1-to-clear of the status error bits. At any unmapped offset it is dropped.
- R4: A local-error pulse sets status bit 1 and a remote-error pulse sets status bit 2, at the next edge.
- R5: A bus write of 1 to status bit 1 or bit 2 clears that bit, and a 0 leaves it unchanged. If a new error pulse and a clear of the same bit fall in the same cycle, the bit stays set.
- R6: While control bit 1 is 1, every error event (either pulse, or link rise) sets the pending bit numbered by control bits 12:8. While control bit 1 is 0, error events leave the pending register alone.
- R7: `irq` is high exactly when at least one pending bit is set. It follows the pending register at the same edge.
- R8: Status bit 0 follows `link_up` one edge later. A 0-to-1 transition of `link_up` also sets the remote-error bit.
- R9: A bus write to 14h clears the pending bits written as 1. If a remote set or an error post hits a bit in the same cycle as a clear, the set wins.
- R10: If a bus write and a remote word target control or pointer in the same cycle, the bus value is stored.
- R11: After reset every register reads 0 and `irq` is low.
- R12: `bus_rdata` shows the register at `bus_addr` in the same cycle, with no wait state. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rmt_valid | input | 1 | A received interrupt status word is present this cycle |
| rmt_word | input | 32 | Received interrupt status word |
| lerr_pulse | input | 1 | One-cycle pulse: inbound packet error |
| rerr_pulse | input | 1 | One-cycle pulse: far end reported a transmit error |
| link_up | input | 1 | Link-established level |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset for read and write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Level interrupt to the host CPU |

## Verification
Every register effect lands at the first clock edge after the stimulus cycle. This covers remote words, error pulses, link rise, bus writes and acknowledges. `irq` changes at that same edge, because it is taken straight from the pending register. `bus_rdata` is valid in the same cycle the address is applied. The bench therefore drives inputs just after an edge, advances exactly one edge, and then reads back one time unit later. Read checks allow one time unit after the address changes. The same-cycle races are staged inside a single driven cycle: set against clear, and bus against remote.

// File: rtl/lnk_irq_pkg.sv
// Package: register offsets, field positions and register indices shared
// by the interrupt aggregator and its checker.
package lnk_irq_pkg;

    // Register index used by the address decoders and the read mux.
    typedef enum int {
        RG_CTRL = 0,
        RG_STAT = 1,
        RG_PTR  = 2,
        RG_PEND = 3
    } reg_idx_e;

    localparam int NREG = 4;

    // Byte offsets; the pending offset is fixed because remote routing relies on it.
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_STAT = 'h04;
    localparam int OFS_PTR  = 'h08;
    localparam int OFS_PEND = 'h14;

    // Control register fields.
    localparam int CTRL_LOC_BIT = 0;
    localparam int CTRL_EIE_BIT = 1;
    localparam int CTRL_VEC_LSB = 8;

    // Status register fields.
    localparam int STAT_LINK_BIT = 0;
    localparam int STAT_LERR_BIT = 1;
    localparam int STAT_RERR_BIT = 2;

    // Offset of a register by index, usable in constant context.
    function automatic int reg_ofs(input int idx);
        case (idx)
            RG_CTRL: return OFS_CTRL;
            RG_STAT: return OFS_STAT;
            RG_PTR:  return OFS_PTR;
            default: return OFS_PEND;
        endcase
    endfunction

endpackage

// File: rtl/lnk_irq_dec.sv
// Address decoder: turns an enable and a byte offset into a one-hot register
// select. Assumes exact offset match; misaligned or unlisted offsets select nothing.
module lnk_irq_dec
    import lnk_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel
);

    // One comparator per register offset.
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign sel[g] = en && (addr == ADDR_W'(reg_ofs(g)));
    end

endmodule

// File: rtl/lnk_irq_cfg.sv
// Control and pointer registers. Each can be written from the bus or from a
// routed remote word; the bus wins when both hit the same register in a cycle.
// Assumes the select inputs are already qualified by their strobes.
module lnk_irq_cfg #(
    parameter int ADDR_W = 8,
    parameter int VEC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ctrl_sel,
    input  logic              bus_ptr_sel,
    input  logic              rmt_ctrl_sel,
    input  logic              rmt_ptr_sel,
    input  logic              bus_loc,
    input  logic              bus_eie,
    input  logic [VEC_W-1:0]  bus_vec,
    input  logic [ADDR_W-1:0] bus_ptr,
    input  logic              rmt_loc,
    input  logic              rmt_eie,
    input  logic [VEC_W-1:0]  rmt_vec,
    input  logic [ADDR_W-1:0] rmt_ptr,
    output logic              ctrl_loc,
    output logic              ctrl_eie,
    output logic [VEC_W-1:0]  ctrl_vec,
    output logic [ADDR_W-1:0] ptr_q
);

    // Control register update, bus before remote.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_loc <= 1'b0;
            ctrl_eie <= 1'b0;
            ctrl_vec <= '0;
        end else if (bus_ctrl_sel) begin
            ctrl_loc <= bus_loc;
            ctrl_eie <= bus_eie;
            ctrl_vec <= bus_vec;
        end else if (rmt_ctrl_sel) begin
            ctrl_loc <= rmt_loc;
            ctrl_eie <= rmt_eie;
            ctrl_vec <= rmt_vec;
        end
    end

    // Pointer register update, bus before remote.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (bus_ptr_sel) begin
            ptr_q <= bus_ptr;
        end else if (rmt_ptr_sel) begin
            ptr_q <= rmt_ptr;
        end
    end

endmodule

// File: rtl/lnk_irq_errstat.sv
// Error and link status. Holds the two sticky error flags and the registered
// link level, and emits a one-cycle post request for each error event
// (error pulse or first cycle of link-up). Set beats write-1-to-clear.
module lnk_irq_errstat (
    input  logic clk,
    input  logic rst_n,
    input  logic lerr_pulse,
    input  logic rerr_pulse,
    input  logic link_up,
    input  logic clr_lerr,
    input  logic clr_rerr,
    output logic lerr_q,
    output logic rerr_q,
    output logic link_q,
    output logic post
);

    logic link_rise;

    // Detect the first cycle of an established link.
    always_comb begin
        link_rise = link_up && !link_q;
        post      = lerr_pulse || rerr_pulse || link_rise;
    end

    // Sticky flags and link level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lerr_q <= 1'b0;
            rerr_q <= 1'b0;
            link_q <= 1'b0;
        end else begin
            lerr_q <= lerr_pulse || (lerr_q && !clr_lerr);
            rerr_q <= rerr_pulse || link_rise || (rerr_q && !clr_rerr);
            link_q <= link_up;
        end
    end

endmodule

// File: rtl/lnk_irq_pend.sv
// Pending register. Each bit is set by a routed remote word or by an error
// post aimed at it, and cleared by a bus write-1-to-clear; set wins.
// Assumes the pending width equals 2**VEC_W.
module lnk_irq_pend #(
    parameter int VEC_W = 5,
    localparam int NPEND = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [NPEND-1:0] set_word,
    input  logic             clr_en,
    input  logic [NPEND-1:0] clr_word,
    input  logic             post,
    input  logic             post_en,
    input  logic [VEC_W-1:0] vec,
    output logic [NPEND-1:0] pend_q
);

    // One storage bit per pending line with its own set/clear terms.
    for (genvar g = 0; g < NPEND; g++) begin : g_bit
        logic hit_set;
        logic hit_clr;

        // Collect the set and clear requests for this bit.
        always_comb begin
            hit_set = (set_en && set_word[g])
                   || (post && post_en && (vec == VEC_W'(g)));
            hit_clr = clr_en && clr_word[g];
        end

        // Pending bit, set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
            end else begin
                pend_q[g] <= hit_set || (pend_q[g] && !hit_clr);
            end
        end
    end

endmodule

// File: rtl/lnk_irq_aggr.sv
// Interrupt pending aggregator for a serial link port. Routes received
// interrupt words by the pointer register, posts error events on a chosen
// pending bit, serves a zero-wait register bus and drives a level interrupt.
// Assumes single-cycle pulses on the error inputs and a synchronous link_up.
module lnk_irq_aggr
    import lnk_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int VEC_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rmt_valid,
    input  logic [DATA_W-1:0] rmt_word,
    input  logic              lerr_pulse,
    input  logic              rerr_pulse,
    input  logic              link_up,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [NREG-1:0]   bus_sel;
    logic [NREG-1:0]   rmt_sel;
    logic [NREG-1:0]   rd_sel;
    logic              rmt_go;
    logic              ctrl_loc;
    logic              ctrl_eie;
    logic [VEC_W-1:0]  ctrl_vec;
    logic [ADDR_W-1:0] ptr_q;
    logic              lerr_q;
    logic              rerr_q;
    logic              link_q;
    logic              err_post;
    logic              clr_lerr;
    logic              clr_rerr;
    logic [DATA_W-1:0] pend_q;

    // A remote word is acted on only while local delivery is enabled.
    assign rmt_go = rmt_valid && ctrl_loc;

    lnk_irq_dec #(.ADDR_W(ADDR_W)) u_dec_bus (
        .en   (bus_wr),
        .addr (bus_addr),
        .sel  (bus_sel)
    );

    lnk_irq_dec #(.ADDR_W(ADDR_W)) u_dec_rmt (
        .en   (rmt_go),
        .addr (ptr_q),
        .sel  (rmt_sel)
    );

    lnk_irq_dec #(.ADDR_W(ADDR_W)) u_dec_rd (
        .en   (1'b1),
        .addr (bus_addr),
        .sel  (rd_sel)
    );

    lnk_irq_cfg #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_ctrl_sel (bus_sel[RG_CTRL]),
        .bus_ptr_sel  (bus_sel[RG_PTR]),
        .rmt_ctrl_sel (rmt_sel[RG_CTRL]),
        .rmt_ptr_sel  (rmt_sel[RG_PTR]),
        .bus_loc      (bus_wdata[CTRL_LOC_BIT]),
        .bus_eie      (bus_wdata[CTRL_EIE_BIT]),
        .bus_vec      (bus_wdata[CTRL_VEC_LSB +: VEC_W]),
        .bus_ptr      (bus_wdata[ADDR_W-1:0]),
        .rmt_loc      (rmt_word[CTRL_LOC_BIT]),
        .rmt_eie      (rmt_word[CTRL_EIE_BIT]),
        .rmt_vec      (rmt_word[CTRL_VEC_LSB +: VEC_W]),
        .rmt_ptr      (rmt_word[ADDR_W-1:0]),
        .ctrl_loc     (ctrl_loc),
        .ctrl_eie     (ctrl_eie),
        .ctrl_vec     (ctrl_vec),
        .ptr_q        (ptr_q)
    );

    // Write-1-to-clear of the error flags from either write source.
    always_comb begin
        clr_lerr = (bus_sel[RG_STAT] && bus_wdata[STAT_LERR_BIT])
                || (rmt_sel[RG_STAT] && rmt_word[STAT_LERR_BIT]);
        clr_rerr = (bus_sel[RG_STAT] && bus_wdata[STAT_RERR_BIT])
                || (rmt_sel[RG_STAT] && rmt_word[STAT_RERR_BIT]);
    end

    lnk_irq_errstat u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .lerr_pulse (lerr_pulse),
        .rerr_pulse (rerr_pulse),
        .link_up    (link_up),
        .clr_lerr   (clr_lerr),
        .clr_rerr   (clr_rerr),
        .lerr_q     (lerr_q),
        .rerr_q     (rerr_q),
        .link_q     (link_q),
        .post       (err_post)
    );

    lnk_irq_pend #(.VEC_W(VEC_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (rmt_sel[RG_PEND]),
        .set_word (rmt_word),
        .clr_en   (bus_sel[RG_PEND]),
        .clr_word (bus_wdata),
        .post     (err_post),
        .post_en  (ctrl_eie),
        .vec      (ctrl_vec),
        .pend_q   (pend_q)
    );

    // Level interrupt from any pending bit.
    assign irq = |pend_q;

    // Zero-wait read mux; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_sel[RG_CTRL]) begin
            bus_rdata[CTRL_LOC_BIT]               = ctrl_loc;
            bus_rdata[CTRL_EIE_BIT]               = ctrl_eie;
            bus_rdata[CTRL_VEC_LSB +: VEC_W]      = ctrl_vec;
        end
        if (rd_sel[RG_STAT]) begin
            bus_rdata[STAT_LINK_BIT] = link_q;
            bus_rdata[STAT_LERR_BIT] = lerr_q;
            bus_rdata[STAT_RERR_BIT] = rerr_q;
        end
        if (rd_sel[RG_PTR]) begin
            bus_rdata[ADDR_W-1:0] = ptr_q;
        end
        if (rd_sel[RG_PEND]) begin
            bus_rdata = pend_q;
        end
    end

endmodule

// File: rtl/lnk_irq_chk.sv
// Checker for the aggregator: relates inputs, internal registers and the
// interrupt output over time. Attached to every instance by the bind below.
module lnk_irq_chk
    import lnk_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int VEC_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rmt_valid,
    input logic [DATA_W-1:0] rmt_word,
    input logic              lerr_pulse,
    input logic              rerr_pulse,
    input logic              link_up,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              ctrl_loc,
    input logic              ctrl_eie,
    input logic [VEC_W-1:0]  ctrl_vec,
    input logic [ADDR_W-1:0] ptr_q,
    input logic              lerr_q,
    input logic              rerr_q,
    input logic              link_q,
    input logic [DATA_W-1:0] pend_q
);

    a_r1_remote_or_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_valid && ctrl_loc && ptr_q == ADDR_W'(OFS_PEND))
        |=> ((pend_q & $past(rmt_word)) == $past(rmt_word)));

    a_r2_remote_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_valid && !ctrl_loc && !bus_wr && !lerr_pulse && !rerr_pulse
         && !(link_up && !link_q))
        |=> (pend_q == $past(pend_q)));

    a_r4_lerr_set: assert property (@(posedge clk) disable iff (!rst_n)
        lerr_pulse |=> lerr_q);

    a_r5_lerr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_STAT) && bus_wdata[STAT_LERR_BIT]
         && !lerr_pulse)
        |=> !lerr_q);

    a_r6_post_vector: assert property (@(posedge clk) disable iff (!rst_n)
        ((lerr_pulse || rerr_pulse) && ctrl_eie)
        |=> pend_q[$past(ctrl_vec)]);

    a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (pend_q != '0));

    a_r8_link_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !link_q) |=> (rerr_q && link_q));

    a_r11_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && ptr_q == '0 && !ctrl_loc && !rerr_q));

endmodule

bind lnk_irq_aggr lnk_irq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .VEC_W  (VEC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rmt_valid  (rmt_valid),
    .rmt_word   (rmt_word),
    .lerr_pulse (lerr_pulse),
    .rerr_pulse (rerr_pulse),
    .link_up    (link_up),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq        (irq),
    .ctrl_loc   (ctrl_loc),
    .ctrl_eie   (ctrl_eie),
    .ctrl_vec   (ctrl_vec),
    .ptr_q      (ptr_q),
    .lerr_q     (lerr_q),
    .rerr_q     (rerr_q),
    .link_q     (link_q),
    .pend_q     (pend_q)
);

// File: tb/sim_lnk_irq_aggr.sv
// Bench: sweeps the pointer over every offset and the vector over every
// pending bit, plus the same-cycle races, with expected values computed here.
module sim_lnk_irq_aggr;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_STAT = 8'h04;
    localparam logic [7:0] A_PTR  = 8'h08;
    localparam logic [7:0] A_PEND = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rmt_valid = 1'b0;
    logic [31:0] rmt_word = '0;
    logic        lerr_pulse = 1'b0;
    logic        rerr_pulse = 1'b0;
    logic        link_up = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    lnk_irq_aggr u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rmt_valid  (rmt_valid),
        .rmt_word   (rmt_word),
        .lerr_pulse (lerr_pulse),
        .rerr_pulse (rerr_pulse),
        .link_up    (link_up),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rmt(input logic [31:0] w);
        rmt_valid = 1'b1; rmt_word = w;
        step();
        rmt_valid = 1'b0;
    endtask

    task automatic errs(input bit l, input bit r);
        lerr_pulse = l; rerr_pulse = r;
        step();
        lerr_pulse = 1'b0; rerr_pulse = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;

        // R11 / R12: reset values and unmapped reads.
        chk_rd("R11 ctrl", A_CTRL, 0);
        chk_rd("R11 stat", A_STAT, 0);
        chk_rd("R11 ptr",  A_PTR,  0);
        chk_rd("R11 pend", A_PEND, 0);
        chk("R11 irq", {31'd0, irq}, 0);
        chk_rd("R12 unmapped 10h", 8'h10, 0);
        chk_rd("R12 unmapped 15h", 8'h15, 0);

        // R1 / R7 / R9: accumulate remote words, acknowledge, irq level.
        wr(A_CTRL, 32'h1);
        wr(A_PTR, A_PEND);
        rmt(32'h0000_0001);
        rmt(32'h8000_0000);
        chk_rd("R1 or-accumulate", A_PEND, 32'h8000_0001);
        chk("R7 irq high", {31'd0, irq}, 1);
        wr(A_PEND, 32'h0000_0001);
        chk_rd("R9 partial clear", A_PEND, 32'h8000_0000);
        chk("R7 irq still high", {31'd0, irq}, 1);
        wr(A_PEND, 32'hFFFF_FFFF);
        chk("R7 irq low", {31'd0, irq}, 0);

        // R9: remote set against bus clear in one cycle.
        rmt(32'h0000_00F0);
        rmt_valid = 1'b1; rmt_word = 32'h10;
        bus_wr = 1'b1; bus_addr = A_PEND; bus_wdata = 32'h30;
        step();
        rmt_valid = 1'b0; bus_wr = 1'b0;
        chk_rd("R9 set wins", A_PEND, 32'h0000_00D0);
        wr(A_PEND, 32'hFFFF_FFFF);

        // R2: local delivery off.
        wr(A_CTRL, 32'h0);
        rmt(32'hFFFF_FFFF);
        chk_rd("R2 pend untouched", A_PEND, 0);
        chk_rd("R2 ptr untouched", A_PTR, {24'd0, A_PEND});

        // R3: sweep the pointer over every offset.
        for (int p = 0; p < 256; p++) begin
            logic [31:0] e_ctrl, e_ptr, e_stat, e_pend;
            wr(A_CTRL, 32'h1);
            wr(A_PEND, 32'hFFFF_FFFF);
            errs(1'b1, 1'b1);
            wr(A_PTR, p);
            rmt(32'h0000_1F07);
            e_ctrl = (p == 8'h00) ? 32'h1F03 : 32'h1;
            e_ptr  = (p == 8'h08) ? 32'h07 : p;
            e_stat = (p == 8'h04) ? 32'h0 : 32'h6;
            e_pend = (p == 8'h14) ? 32'h1F07 : 32'h0;
            chk_rd("R3 ctrl", A_CTRL, e_ctrl);
            chk_rd("R3 ptr",  A_PTR,  e_ptr);
            chk_rd("R3 stat", A_STAT, e_stat);
            chk_rd("R3 pend", A_PEND, e_pend);
            wr(A_STAT, 32'h6);
        end

        // R4 / R6: error posting onto each vector.
        for (int v = 0; v < 32; v++) begin
            wr(A_CTRL, 32'h2 | (v << 8));
            wr(A_PEND, 32'hFFFF_FFFF);
            errs(1'b1, 1'b0);
            chk_rd("R4 lerr flag", A_STAT, 32'h2);
            chk_rd("R6 lerr post", A_PEND, 32'h1 << v);
            wr(A_STAT, 32'h6);
            wr(A_PEND, 32'hFFFF_FFFF);
            errs(1'b0, 1'b1);
            chk_rd("R4 rerr flag", A_STAT, 32'h4);
            chk_rd("R6 rerr post", A_PEND, 32'h1 << v);
            wr(A_STAT, 32'h6);
        end
        wr(A_PEND, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h1F00);
        errs(1'b1, 1'b1);
        chk_rd("R6 posting off", A_PEND, 0);
        chk("R7 irq off", {31'd0, irq}, 0);

        // R5: write-0 no effect, write-1 clear, set beats clear.
        wr(A_STAT, 32'h0);
        chk_rd("R5 write zero", A_STAT, 32'h6);
        wr(A_STAT, 32'h2);
        chk_rd("R5 clear lerr", A_STAT, 32'h4);
        lerr_pulse = 1'b1;
        bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h2;
        step();
        lerr_pulse = 1'b0; bus_wr = 1'b0;
        chk_rd("R5 set wins", A_STAT, 32'h6);
        wr(A_STAT, 32'h6);
        chk_rd("R5 both clear", A_STAT, 32'h0);

        // R10: bus beats remote on control and on pointer.
        wr(A_CTRL, 32'h1);
        wr(A_PTR, A_CTRL);
        rmt_valid = 1'b1; rmt_word = 32'h1F03;
        bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h0301;
        step();
        rmt_valid = 1'b0; bus_wr = 1'b0;
        chk_rd("R10 ctrl bus wins", A_CTRL, 32'h0301);
        wr(A_PTR, A_PTR);
        rmt_valid = 1'b1; rmt_word = 32'h55;
        bus_wr = 1'b1; bus_addr = A_PTR; bus_wdata = A_PEND;
        step();
        rmt_valid = 1'b0; bus_wr = 1'b0;
        chk_rd("R10 ptr bus wins", A_PTR, {24'd0, A_PEND});

        // R8: link bit and spurious remote error on link rise.
        wr(A_CTRL, 32'h0);
        link_up = 1'b1;
        step();
        chk_rd("R8 link rise", A_STAT, 32'h5);
        wr(A_STAT, 32'h4);
        step();
        step();
        chk_rd("R8 no repeat", A_STAT, 32'h1);
        link_up = 1'b0;
        step();
        chk_rd("R8 link drop", A_STAT, 32'h0);
        wr(A_CTRL, 32'h0702);
        link_up = 1'b1;
        step();
        chk_rd("R8 rise posts", A_PEND, 32'h80);
        chk_rd("R8 rise stat", A_STAT, 32'h5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule